// File: doc/BRIEF.md
# Capacitor Bank Stacking Controller

This block decides how a bank of equal storage capacitors is wired so that an energy-harvesting load can draw nearly all of the stored charge. A bank of four capacitors is arranged as one of three levels: level 0 puts all four in parallel, level 1 makes two parallel strings of two capacitors in series, and level 2 puts all four in series. Each step up the ladder halves the number of parallel strings, and each step down doubles it. Because the bank window is a 2:1 voltage ratio, a restack brings the bank voltage back to about twice its trip level.

A clocked analog comparator compares the scaled bank voltage with a scaled reference. Its result is valid only on the cycles where `cmp_tick` is high. While discharging, a low bank moves the ladder one level up. While charging, a high bank moves it one level down. A trip counts only when it is seen on two sample ticks in a row, in the same mode. After a move, every switch group is opened for a set number of dead cycles, so that old and new connections never overlap. Trips are then ignored for a blanking interval while the bank voltage settles. Each accepted move raises a one-cycle `stack_pulse`.

Top module: `bank_stack_ctrl`

## Requirements
- R1: While `rst` is high, and for DEAD_CYC (default 2) cycles after it falls, `cfg_code` is 0, `sw_en` is all zero and `stack_pulse` is 0. After that, `sw_en` is 3'b001.
- R2: `cfg_code` carries the level: 2'b00 = all parallel, 2'b01 = two strings of two, 2'b10 = all series. Code 2'b11 is never output, and the controller returns to level 0 if the register ever holds it. When the switches are on, `sw_en` is one-hot, with bit k set for level k. At all times at most one bit of `sw_en` is high.
- R3: With `mode_chg` = 0 (discharging), a trip is `cmp_above` = 0 on a tick. Two consecutive trip ticks raise the level by one.
- R4: With `mode_chg` = 1 (charging), a trip is `cmp_above` = 1 on a tick. Two consecutive trip ticks lower the level by one.
- R5: At level 2, discharge trips have no effect. At level 0, charge trips have no effect. In both cases `cfg_code` stays the same and no pulse appears.
- R6: A tick without a trip cancels a pending trip. A trip tick in the other mode also cancels it and starts a new pending trip in that mode. Cycles without a tick leave a pending trip untouched.
- R7: From the cycle after an accepted move, `sw_en` is all zero for DEAD_CYC cycles and then shows the new level. `sw_en` never changes directly from one nonzero pattern to another.
- R8: Ticks are ignored during the dead cycles and the following BLANK_CYC (default 8) cycles. A trip pending at the time of a move is dropped.
- R9: `stack_pulse` is high for exactly one cycle, which is the first cycle that shows the new `cfg_code`.
- R10: `cmp_above` and `mode_chg` have no effect in cycles where `cmp_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_tick | input | 1 | High in cycles where the comparator result is valid |
| cmp_above | input | 1 | Comparator result: scaled bank voltage above scaled reference |
| mode_chg | input | 1 | 1 = bank charging, 0 = bank discharging |
| cfg_code | output | 2 | Current ladder level sent to the switch matrix |
| sw_en | output | 3 | One enable per switch group, one-hot per level, all zero in dead time |
| stack_pulse | output | 1 | One-cycle strobe for each accepted move |

## Verification
The assertions assume that reset is applied before the first useful edge. They also assume that the inputs are stable at each rising edge, so that a trip on a tick cycle is seen exactly once. The stimulus changes every input on the falling edge and starts with three cycles of reset.

Directed sequences cover the following cases:
- both walks along the ladder, in each direction;
- trips at both ends of the ladder;
- broken and mode-flipped trip pairs;
- ticks that fall inside the blanking window;
- ticks held high on consecutive cycles.

A long pseudo-random phase then mixes tick density, comparator level and mode changes. Throughout, a behavioural model runs beside the design and is compared with it on every cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Sequencing phase after reset or a move
    typedef enum logic [1:0] {
        PH_DEAD  = 2'd0,
        PH_BLANK = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // A trip waiting for its confirming sample
    typedef struct packed {
        logic valid;
        logic charging;
    } streak_t;

    // Number of ladder levels for a power-of-two bank
    function automatic int unsigned cfg_levels(input int unsigned ncaps);
        return $clog2(ncaps) + 1;
    endfunction

    // Comparator sense that asks for a move in the given mode
    function automatic logic trip_seen(input logic above, input logic charging);
        return charging ? above : !above;
    endfunction

endpackage

// File: rtl/bsc_seq_timer.sv
module bsc_seq_timer import bsc_pkg::*; #(
    parameter int unsigned DEAD_CYC  = 2,
    parameter int unsigned BLANK_CYC = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   run,
    output logic   out_en
);
    localparam int unsigned MAXC = (DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_DEAD;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_DEAD: begin
                    if (cnt == DEAD_LAST) begin
                        phase <= PH_BLANK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_BLANK: begin
                    if (cnt == BLANK_LAST) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_RUN: begin
                    if (start) begin
                        phase <= PH_DEAD;
                        cnt   <= '0;
                    end
                end
                default: begin
                    phase <= PH_DEAD;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign run    = (phase == PH_RUN);
    assign out_en = (phase != PH_DEAD);

    // R7: a move always opens every switch on the next cycle
    assert_dead_after_move_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == PH_DEAD));

    // R8: trip evaluation resumes only after the blanking phase
    assert_run_from_blank_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> ($past(phase) == PH_BLANK));

endmodule

// File: rtl/bsc_trip_filter.sv
module bsc_trip_filter import bsc_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic above,
    input  logic charging,
    input  logic at_top,
    input  logic at_bot,
    output logic accept
);
    streak_t streak;
    logic    room;
    logic    qual;

    // A move is possible only away from the end of the ladder it would leave
    assign room   = charging ? !at_bot : !at_top;
    assign qual   = run && tick && trip_seen(above, charging) && room;
    assign accept = qual && streak.valid && (streak.charging == charging);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            streak <= '0;
        end else if (tick) begin
            if (qual && !accept) begin
                streak.valid    <= 1'b1;
                streak.charging <= charging;
            end else begin
                streak <= '0;
            end
        end
    end

    // R8: the first run cycle can never confirm a trip
    assert_no_accept_after_blank_R8: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(run));

endmodule

// File: rtl/bsc_ladder.sv
module bsc_ladder #(
    parameter int unsigned NUM_CFG = 3,
    parameter int unsigned CODE_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              charging,
    output logic [CODE_W-1:0] cfg,
    output logic              pulse,
    output logic              at_top,
    output logic              at_bot
);
    localparam logic [CODE_W-1:0] TOP = CODE_W'(NUM_CFG - 1);

    logic illegal;

    assign illegal = (cfg > TOP);
    assign at_top  = (cfg == TOP);
    assign at_bot  = (cfg == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (illegal) begin
                cfg <= '0;
            end else if (accept) begin
                if (charging && !at_bot) begin
                    cfg   <= cfg - CODE_W'(1);
                    pulse <= 1'b1;
                end else if (!charging && !at_top) begin
                    cfg   <= cfg + CODE_W'(1);
                    pulse <= 1'b1;
                end
            end
        end
    end

    // R3: a discharge move climbs exactly one level
    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !charging && !at_top && !illegal) |=> (cfg == $past(cfg) + CODE_W'(1)));

    // R4: a charge move descends exactly one level
    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && charging && !at_bot && !illegal) |=> (cfg == $past(cfg) - CODE_W'(1)));

    // R5: the ends of the ladder saturate
    assert_hold_top_R5: assert property (@(posedge clk) disable iff (rst)
        (at_top && !charging) |=> at_top);
    assert_hold_bot_R5: assert property (@(posedge clk) disable iff (rst)
        (at_bot && charging) |=> at_bot);

    // R9: the strobe marks a cycle whose level differs from the one before
    assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (cfg != $past(cfg)));

endmodule

// File: rtl/bsc_sw_decode.sv
module bsc_sw_decode #(
    parameter int unsigned NUM_CFG = 3,
    parameter int unsigned CODE_W  = 2
) (
    input  logic [CODE_W-1:0]  cfg,
    input  logic               out_en,
    output logic [NUM_CFG-1:0] sw_en
);
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_group
        assign sw_en[g] = out_en && (cfg == CODE_W'(g));
    end
endmodule

// File: rtl/bank_stack_ctrl.sv
module bank_stack_ctrl import bsc_pkg::*; #(
    parameter  int unsigned NUM_CAPS  = 4,
    parameter  int unsigned DEAD_CYC  = 2,
    parameter  int unsigned BLANK_CYC = 8,
    localparam int unsigned NUM_CFG   = cfg_levels(NUM_CAPS),
    localparam int unsigned CODE_W    = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmp_tick,
    input  logic               cmp_above,
    input  logic               mode_chg,
    output logic [CODE_W-1:0]  cfg_code,
    output logic [NUM_CFG-1:0] sw_en,
    output logic               stack_pulse
);
    phase_e phase;
    logic   run;
    logic   out_en;
    logic   accept;
    logic   at_top;
    logic   at_bot;

    bsc_seq_timer #(
        .DEAD_CYC  (DEAD_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .phase  (phase),
        .run    (run),
        .out_en (out_en)
    );

    bsc_trip_filter filter_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (cmp_tick),
        .above    (cmp_above),
        .charging (mode_chg),
        .at_top   (at_top),
        .at_bot   (at_bot),
        .accept   (accept)
    );

    bsc_ladder #(
        .NUM_CFG (NUM_CFG),
        .CODE_W  (CODE_W)
    ) ladder_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .charging (mode_chg),
        .cfg      (cfg_code),
        .pulse    (stack_pulse),
        .at_top   (at_top),
        .at_bot   (at_bot)
    );

    bsc_sw_decode #(
        .NUM_CFG (NUM_CFG),
        .CODE_W  (CODE_W)
    ) decode_i (
        .cfg    (cfg_code),
        .out_en (out_en),
        .sw_en  (sw_en)
    );

    // R2: at most one switch group is ever closed
    assert_sw_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_en));

    // R7: no direct hand-over between two closed switch patterns
    assert_break_before_make_R7: assert property (@(posedge clk) disable iff (rst)
        ((sw_en != '0) && ($past(sw_en) != '0)) |-> (sw_en == $past(sw_en)));

    // R9: a strobe is always followed by the dead interval
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        stack_pulse |-> ((sw_en == '0) && !$past(stack_pulse)));

endmodule

// File: tb/bank_stack_ctrl_tb_top.sv
module bank_stack_ctrl_tb_top;
    localparam int DEAD  = 2;
    localparam int BLANK = 8;
    localparam int TOPL  = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       cmp_tick = 1'b0;
    logic       cmp_above = 1'b1;
    logic       mode_chg = 1'b0;
    logic [1:0] cfg_code;
    logic [2:0] sw_en;
    logic       stack_pulse;

    bank_stack_ctrl #(.NUM_CAPS(4), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cmp_tick    (cmp_tick),
        .cmp_above   (cmp_above),
        .mode_chg    (mode_chg),
        .cfg_code    (cfg_code),
        .sw_en       (sw_en),
        .stack_pulse (stack_pulse)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Behavioural reference: remaining dead / blank cycles, level, streak
    int m_cfg = 0, m_dead = DEAD, m_blank = BLANK;
    bit m_streak = 1'b0, m_sdir = 1'b0, m_pulse = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 0; m_dead = DEAD; m_blank = BLANK;
            m_streak = 1'b0; m_pulse = 1'b0;
        end else begin
            m_pulse = 1'b0;
            if (m_dead > 0) begin
                m_dead--; m_streak = 1'b0;
            end else if (m_blank > 0) begin
                m_blank--; m_streak = 1'b0;
            end else if (cmp_tick) begin
                bit want;
                want = mode_chg ? (cmp_above && m_cfg > 0) : (!cmp_above && m_cfg < TOPL);
                if (!want) begin
                    m_streak = 1'b0;
                end else if (m_streak && m_sdir == mode_chg) begin
                    m_cfg   = mode_chg ? m_cfg - 1 : m_cfg + 1;
                    m_pulse = 1'b1;
                    m_dead  = DEAD; m_blank = BLANK; m_streak = 1'b0;
                end else begin
                    m_streak = 1'b1; m_sdir = mode_chg;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            logic [2:0] exp_sw;
            exp_sw = (m_dead > 0) ? 3'b000 : 3'(1 << m_cfg);
            n_cmp++;
            if (cfg_code !== 2'(m_cfg) || sw_en !== exp_sw || stack_pulse !== m_pulse) begin
                n_bad++;
                $display("FAIL %s t=%0t cfg_code/sw_en/pulse actual %0d/%b/%0d expected %0d/%b/%0d",
                         cur_req, $time, cfg_code, sw_en, stack_pulse, m_cfg, exp_sw, m_pulse);
            end
        end
    end

    task automatic idle(input int n);
        cmp_tick = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic samp(input bit above, input bit chg);
        cmp_tick = 1'b1; cmp_above = above; mode_chg = chg;
        @(negedge clk);
        cmp_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic burst(input bit above, input bit chg, input int n);
        cmp_tick = 1'b1; cmp_above = above; mode_chg = chg;
        repeat (n) @(negedge clk);
        cmp_tick = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(DEAD + BLANK + 3);

        cur_req = "R10";                 // trip level held, no ticks
        cmp_above = 1'b0; mode_chg = 1'b0;
        idle(12);
        mode_chg = 1'b1; cmp_above = 1'b1;
        idle(6);

        cur_req = "R3 R7 R9";            // discharge walk 0 -> 1 -> 2
        samp(0, 0); samp(0, 0); idle(12);
        samp(0, 0); idle(3); samp(0, 0); idle(12);

        cur_req = "R5";                  // discharge trips at the top
        repeat (4) samp(0, 0);
        idle(4);

        cur_req = "R6";                  // broken pair then a valid pair
        samp(1, 1); samp(0, 1); samp(1, 1); idle(2); samp(1, 1); idle(12);
        samp(1, 1); samp(0, 0); samp(0, 0); idle(12);

        cur_req = "R8";                  // ticks inside dead and blank
        samp(1, 1); samp(1, 1);
        repeat (5) samp(1, 1);
        samp(1, 1); samp(1, 1); idle(12);

        cur_req = "R4 R5";               // reach the bottom, then saturate
        samp(1, 1); samp(1, 1); idle(12);
        repeat (4) samp(1, 1);

        cur_req = "R3 R4";               // ticks on consecutive cycles
        burst(0, 0, 30);
        burst(1, 1, 30);
        idle(12);

        cur_req = "R3 R4 R6 R8 R10";     // pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cmp_tick  = lfsr[0] & lfsr[3];
            cmp_above = lfsr[5] ^ (lfsr[9] & lfsr[11]);
            if ((i % 97) == 0) mode_chg = lfsr[7];
            if (lfsr[2] & lfsr[8] & lfsr[14] & lfsr[1]) mode_chg = ~mode_chg;
            @(negedge clk);
        end
        idle(4);
        summary();
    end
endmodule